// File: doc/BRIEF.md
# Dual-Channel Interrupt and Output-Port Controller

This block is the shared-control slice of a two-channel serial controller. It takes the transmitter-ready and receiver-ready levels of each channel and packs them into one interrupt status byte. Each channel owns one nibble of that byte. A mask register sits at the same bus address as the status byte, and only a write reaches it. The block drives an active-low interrupt request. The request is low while any status bit whose mask bit is set is at 1.

The block also owns a general-purpose output port. That port is changed only through two write-one strobe addresses, one that sets bits and one that clears them, and never by a plain register load. The block shows the raw levels of the input pins at a read address. It also holds two write-only configuration bytes for neighbouring logic: an output-port configuration byte and an auxiliary control byte.

The bus is byte-wide with a 4-bit address. A write takes effect at the clock edge on which the write strobe is high. Reads are combinational from the address and have no side effects. The channels and the counter/timer sit outside this block and receive nothing back from it.

Top module: `dcio_ctrl`

## Requirements
- R1: After reset the mask is 0, so the interrupt request is high even when every ready input is 1. The output register is 0, so `out_pins` reads 8'hFF. `aux_ctrl` and `op_cfg` read 0.
- R2: A read at address 4'h5 returns the live status. Bit 4x+0 is channel x transmitter ready, bit 4x+1 is channel x receiver ready, and every other bit reads 0.
- R3: `irq_n` is 0 exactly when (status AND mask) is nonzero. A change of a ready input shows on `irq_n` in the same cycle. A mask written at address 4'h5 takes effect from the clock edge of the write.
- R4: Writing address 4'h5 loads the mask and does not alter what a read at 4'h5 returns.
- R5: A write at address 4'hE sets each output-register bit where the data byte has a 1. Bits where the data is 0 keep their value.
- R6: A write at address 4'hF clears each output-register bit where the data byte has a 1. Bits where the data is 0 keep their value.
- R7: `out_pins` is always the bitwise complement of the output register.
- R8: A read at address 4'h4 returns the `in_pins` levels unchanged. An asserted active-low modem signal therefore reads as 0.
- R9: A write at address 4'h4 loads `aux_ctrl`, and a write at address 4'hD loads `op_cfg`. Neither write changes `out_pins` or the mask.
- R10: A write at any other address changes no output. A read at any address other than 4'h4 or 4'h5 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Global register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ch_tx_rdy | input | 2 | Transmitter-ready level per channel |
| ch_rx_rdy | input | 2 | Receiver-ready level per channel |
| in_pins | input | 8 | Raw input-port pin levels |
| irq_n | output | 1 | Active-low interrupt request |
| out_pins | output | 8 | Output-port pins, complement of the output register |
| op_cfg | output | 8 | Output-port configuration byte |
| aux_ctrl | output | 8 | Auxiliary control byte |

## Verification
The status read is tried with four ready patterns: one transmitter alone, one receiver alone, all four levels high, and a crossed pattern. These patterns tell the nibble order and the bit order inside a nibble apart.

The interrupt is tried with a mask that selects only one bit. The bench then raises and drops that bit, raises an unselected bit, and moves the mask to another bit. This separates live-level behaviour from latched behaviour, and it shows that the mask takes effect on the edge of its write.

The output port gets overlapping set and clear bytes and an all-zero clear byte. These show that only the 1 bits of the data act. Writes to the configuration addresses and to unused addresses are followed by reads of the pins and the interrupt, to show that they do not reach the port or the mask.

// File: rtl/dcio_pkg.sv
package dcio_pkg;
  localparam logic [3:0] ADDR_INPORT = 4'h4;
  localparam logic [3:0] ADDR_ISR    = 4'h5;
  localparam logic [3:0] ADDR_OPCFG  = 4'hD;
  localparam logic [3:0] ADDR_OPSET  = 4'hE;
  localparam logic [3:0] ADDR_OPCLR  = 4'hF;
  localparam int NIB_W  = 4;
  localparam int TX_OFS = 0;
  localparam int RX_OFS = 1;

  typedef struct packed {
    logic mask;
    logic aux;
    logic cfg;
    logic set;
    logic clr;
  } wr_sel_t;
endpackage

// File: rtl/dcio_bus_decode.sv
module dcio_bus_decode
  import dcio_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   status,
  input  logic [DW-1:0]   inport,
  output dcio_pkg::wr_sel_t sel,
  output logic [DW-1:0]   rdata
);
  always_comb begin
    sel.mask = wr && (addr == ADDR_ISR);
    sel.aux  = wr && (addr == ADDR_INPORT);
    sel.cfg  = wr && (addr == ADDR_OPCFG);
    sel.set  = wr && (addr == ADDR_OPSET);
    sel.clr  = wr && (addr == ADDR_OPCLR);
  end

  always_comb begin
    case (addr)
      ADDR_ISR:    rdata = status;
      ADDR_INPORT: rdata = inport;
      default:     rdata = '0;
    endcase
  end

  always_comb begin
    assert ($countones({sel.mask, sel.aux, sel.cfg, sel.set, sel.clr}) <= 1)
      else $error("AST_ONE_WRITE_TARGET"); // R10
  end
endmodule

// File: rtl/dcio_irq_unit.sv
module dcio_irq_unit
  import dcio_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tx_rdy,
  input  logic [NCH-1:0] rx_rdy,
  input  logic           wr_mask,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  status,
  output logic           irq_n
);
  localparam int USED_W = NCH * NIB_W;

  logic [DW-1:0] mask_q;
  logic [DW-1:0] packed_st;

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_nib
      always_comb begin
        packed_st[ch*NIB_W +: NIB_W]          = '0;
        packed_st[ch*NIB_W + TX_OFS]          = tx_rdy[ch];
        packed_st[ch*NIB_W + RX_OFS]          = rx_rdy[ch];
      end
    end
    if (DW > USED_W) begin : g_pad
      assign packed_st[DW-1:USED_W] = '0;
    end
  endgenerate

  assign status = packed_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_mask) mask_q <= wdata;
  end

  assign irq_n = ~|(packed_st & mask_q);

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> irq_n); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R9
  AST_NO_READY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_rdy == '0) && (rx_rdy == '0)) |-> irq_n); // R3
endmodule

// File: rtl/dcio_outport.sv
module dcio_outport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_pins
);
  logic [DW-1:0] op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_q <= '0;
    else if (wr_set) op_q <= op_q | wdata;
    else if (wr_clr) op_q <= op_q & ~wdata;
  end

  assign out_pins = ~op_q;

  AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((~out_pins & $past(wdata)) == $past(wdata))); // R5
  AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_pins & ~$past(wdata)) == ($past(out_pins) & ~$past(wdata)))); // R5
  AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_set) |=> ((out_pins & $past(wdata)) == $past(wdata))); // R6
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_set && !wr_clr) |=> $stable(out_pins)); // R10
endmodule

// File: rtl/dcio_ctrl.sv
module dcio_ctrl
  import dcio_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] ch_tx_rdy,
  input  logic [NCH-1:0] ch_rx_rdy,
  input  logic [DW-1:0]  in_pins,
  output logic           irq_n,
  output logic [DW-1:0]  out_pins,
  output logic [DW-1:0]  op_cfg,
  output logic [DW-1:0]  aux_ctrl
);
  wr_sel_t       sel;
  logic [DW-1:0] status;
  logic [DW-1:0] cfg_q;
  logic [DW-1:0] aux_q;

  dcio_bus_decode #(.AW(AW), .DW(DW)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .status (status),
    .inport (in_pins),
    .sel    (sel),
    .rdata  (bus_rdata)
  );

  dcio_irq_unit #(.NCH(NCH), .DW(DW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_rdy  (ch_tx_rdy),
    .rx_rdy  (ch_rx_rdy),
    .wr_mask (sel.mask),
    .wdata   (bus_wdata),
    .status  (status),
    .irq_n   (irq_n)
  );

  dcio_outport #(.DW(DW)) u_op (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_set   (sel.set),
    .wr_clr   (sel.clr),
    .wdata    (bus_wdata),
    .out_pins (out_pins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      aux_q <= '0;
    end else begin
      if (sel.cfg) cfg_q <= bus_wdata;
      if (sel.aux) aux_q <= bus_wdata;
    end
  end

  assign op_cfg   = cfg_q;
  assign aux_ctrl = aux_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_OPCFG) |=> $stable(op_cfg)); // R9
  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_INPORT) |=> $stable(aux_ctrl)); // R9
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_OPCFG) |=> (op_cfg == $past(bus_wdata))); // R9
endmodule

// File: tb/dcio_ctrl_tb.sv
`timescale 1ns/1ps
module dcio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] ch_tx_rdy = 2'b00;
  logic [1:0] ch_rx_rdy = 2'b00;
  logic [7:0] in_pins = 8'h00;
  logic       irq_n;
  logic [7:0] out_pins;
  logic [7:0] op_cfg;
  logic [7:0] aux_ctrl;

  always #5 clk = ~clk;

  dcio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_tx_rdy(ch_tx_rdy),
    .ch_rx_rdy(ch_rx_rdy), .in_pins(in_pins), .irq_n(irq_n),
    .out_pins(out_pins), .op_cfg(op_cfg), .aux_ctrl(aux_ctrl)
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model_op = 8'h00;

  task automatic expect_now(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    #1;
  endtask

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    if (a == 4'hE) model_op = model_op | d;
    if (a == 4'hF) model_op = model_op & ~d;
  endtask

  task automatic bus_read(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #1 expect_now(0, exp, tag);
  endtask

  task automatic set_ready(logic [1:0] tx, logic [1:0] rx);
    @(negedge clk);
    ch_tx_rdy = tx; ch_rx_rdy = rx;
    #1;
  endtask

  initial begin : monitor
    item_t it;
    logic [7:0] act;
    forever begin
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {7'b0, irq_n};
        2: act = out_pins;
        3: act = aux_ctrl;
        default: act = op_cfg;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    set_ready(2'b11, 2'b11);
    expect_now(1, 8'h01, "R1 irq high with mask 0");
    expect_now(2, 8'hFF, "R1 R7 pins high after reset");
    expect_now(3, 8'h00, "R1 aux zero");
    expect_now(4, 8'h00, "R1 cfg zero");

    set_ready(2'b01, 2'b00); bus_read(4'h5, 8'h01, "R2 tx0");
    set_ready(2'b00, 2'b10); bus_read(4'h5, 8'h20, "R2 rx1");
    set_ready(2'b11, 2'b11); bus_read(4'h5, 8'h33, "R2 all");
    set_ready(2'b10, 2'b01); bus_read(4'h5, 8'h12, "R2 crossed");

    set_ready(2'b00, 2'b01);
    bus_write(4'h5, 8'h02);
    expect_now(1, 8'h00, "R3 rx0 masked in");
    bus_read(4'h5, 8'h02, "R4 status after mask write");
    set_ready(2'b00, 2'b00);
    expect_now(1, 8'h01, "R3 level dropped");
    set_ready(2'b10, 2'b00);
    expect_now(1, 8'h01, "R3 tx1 not selected");
    bus_write(4'h5, 8'h10);
    expect_now(1, 8'h00, "R3 mask moved to tx1");
    bus_read(4'h5, 8'h10, "R4 status unchanged by mask");
    bus_write(4'h5, 8'h00);
    expect_now(1, 8'h01, "R3 mask cleared");

    bus_write(4'hE, 8'h0F); expect_now(2, ~model_op, "R5 set low nibble");
    bus_write(4'hE, 8'h30); expect_now(2, ~model_op, "R5 set keeps others");
    bus_write(4'hF, 8'h05); expect_now(2, ~model_op, "R6 clear selected");
    bus_write(4'hF, 8'h00); expect_now(2, 8'hC5, "R6 R7 zero clear no effect");

    in_pins = 8'hA5; bus_read(4'h4, 8'hA5, "R8 input A5");
    in_pins = 8'h3C; bus_read(4'h4, 8'h3C, "R8 input 3C");

    bus_write(4'h4, 8'h66);
    expect_now(3, 8'h66, "R9 aux load");
    expect_now(2, 8'hC5, "R9 aux write leaves pins");
    bus_write(4'hD, 8'h81);
    expect_now(4, 8'h81, "R9 cfg load");
    bus_write(4'hD, 8'h00);
    expect_now(4, 8'h00, "R9 cfg zero");
    expect_now(2, 8'hC5, "R9 cfg write leaves pins");
    set_ready(2'b11, 2'b11);
    expect_now(1, 8'h01, "R9 mask untouched");

    bus_write(4'h0, 8'hFF);
    expect_now(2, 8'hC5, "R10 unused write pins");
    expect_now(1, 8'h01, "R10 unused write irq");
    expect_now(3, 8'h66, "R10 unused write aux");
    bus_read(4'h7, 8'h00, "R10 unused read");
    bus_read(4'hE, 8'h00, "R10 strobe addr read");

    wait (exp_q.size() == 0);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule